// File: doc/BRIEF.md
# ARINC 429 Label Match Filter

This block sits behind four serial receive channels. Each channel hands it a finished 32-bit word, and the block compares that word against a 128-entry table of 16-bit match entries that the host loads. The result tells a downstream store stage three things: whether the word is kept, the receive-RAM slot it goes to, and whether a copy is also pushed into the receiving channel's FIFO. It also gives the general-purpose interrupt line to raise.

The table is scanned one entry per clock, starting at index 0. The scan stops at the first entry that hits. If no entry hits, it ends after the last entry and reports a miss.

A table entry has these fields:

| Field | Bits | Role |
|---|---|---|
| label | 7:0 | Label to compare; zero matches any label |
| source/destination | 9:8 | Value to compare with the word's source/destination bits |
| source/destination wildcard | 10 | When 1, the source/destination comparison always passes |
| FIFO copy | 11 | When 1, a kept word is also pushed into the channel's FIFO |
| channel | 13:12 | Number of the channel the entry applies to |
| interrupt | 15:14 | Interrupt to raise on a hit |

A per-channel all-call enable register can make an incoming source/destination value of 00 always match.

When several channels offer a word, the lowest-numbered channel wins. A busy flag holds off the others while a scan runs.

Top module: `a429_label_filter`

## Requirements
- R1: An entry whose label field (bits 7:0) is zero matches any incoming label (word bits 7:0). A non-zero label field must equal the incoming label.
- R2: The entry's source/destination field (bits 9:8) must equal word bits 9:8, unless entry bit 10 is 1, in which case this comparison always passes.
- R3: When the all-call enable bit for the receiving channel is set (register bit n for channel n), an incoming source/destination value of 00 passes the source/destination comparison. All-call enable bits of other channels have no effect on that word.
- R4: The entry's channel field (bits 13:12) must equal the number of the receiving channel.
- R5: When several entries match, only the lowest-index matching entry is used. `ram_addr_o` equals that index, which is the entry's table address minus the table base.
- R6: On a hit, `fifo_push_o` equals entry bit 11 and `irq_sel_o` equals entry bits 15:14, where 00 means no interrupt. Both are 0 whenever `store_o` is 0.
- R7: If no entry matches, `nomatch_o` pulses for one cycle after entry 127 has been tested, and `store_o` stays low.
- R8: Let the acceptance edge be the clock edge that takes the word. If the first hit is at index k, `store_o` is high for exactly one cycle following clock edge k+1 after the acceptance edge. A miss reports after edge 128. `out_ch_o` and `out_word_o` carry the receiving channel and the word alongside the result.
- R9: Among the channels with a valid word, channel 0 has the highest priority and channel 3 the lowest. `word_ack_o` is one-hot for the winner in the cycle its word is taken. `busy_o` is high during a scan, and no word is taken while it is high.
- R10: A host write (`tbl_we_i`, `tbl_addr_i`, `tbl_wdata_i`) replaces that entry for every later scan.
- R11: After reset, `busy_o`, `store_o`, `nomatch_o`, `fifo_push_o`, `irq_sel_o` and `word_ack_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 7 | Table entry index to write |
| tbl_wdata_i | input | 16 | Entry value |
| allcall_we_i | input | 1 | All-call enable register write strobe |
| allcall_wdata_i | input | 4 | All-call enable, one bit per channel |
| word_valid_i | input | 4 | Per-channel word offered |
| word_data_i | input | 128 | Per-channel 32-bit words, channel n at bits 32n+31:32n |
| word_ack_o | output | 4 | One-hot: word of that channel taken this cycle |
| busy_o | output | 1 | Scan in progress |
| store_o | output | 1 | One-cycle strobe: word kept |
| ram_addr_o | output | 7 | Receive-RAM slot, the index of the first matching entry |
| fifo_push_o | output | 1 | Also push the word into the channel's FIFO |
| irq_sel_o | output | 2 | Interrupt to raise: 0 none, 1 to 3 |
| out_ch_o | output | 2 | Receiving channel of the result |
| out_word_o | output | 32 | Word belonging to the result |
| nomatch_o | output | 1 | One-cycle strobe: no entry matched |

## Verification
The acknowledge is combinational, so the bench samples it in the same cycle it raises a channel's valid, just before the acceptance edge. A hit at index k is due k+1 edges after acceptance, and a miss is due 128 edges after. The bench counts clock edges from acceptance until either strobe appears and compares that count with the expected latency. It samples each strobe and the qualifiers on the falling edge after the registering edge, and samples one cycle later to confirm that the strobe has dropped. For the priority case, the bench holds two requests together and checks that the second is taken only in the first idle cycle after the first result.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;
  localparam int LBL_W = 8;
  localparam int SD_W  = 2;
  localparam int ENT_W = 16;

  // field positions are the table layout seen by the host
  typedef struct packed {
    logic [1:0]       irq;     // 15:14
    logic [1:0]       chan;    // 13:12
    logic             fifo;    // 11
    logic             sd_any;  // 10
    logic [SD_W-1:0]  sd;      // 9:8
    logic [LBL_W-1:0] label;   // 7:0
  } entry_t;

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;
endpackage

// File: rtl/a429_prio_arb.sv
module a429_prio_arb #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] gnt_o,
  output logic [CH_W-1:0] gnt_idx_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_gnt
    if (i == 0) begin : g_first
      assign gnt_o[i] = req_i[i];
    end else begin : g_rest
      assign gnt_o[i] = req_i[i] & ~|req_i[i-1:0];
    end
  end

  always_comb begin
    gnt_idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/a429_match_tbl.sv
module a429_match_tbl
  import a429_filt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output entry_t           rdata_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = entry_t'(mem_q[raddr_i]);
endmodule

// File: rtl/a429_entry_cmp.sv
module a429_entry_cmp
  import a429_filt_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  entry_t           entry_i,
  input  logic [LBL_W-1:0] label_i,
  input  logic [SD_W-1:0]  sd_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             allcall_i,
  output logic             hit_o
);
  logic lbl_ok, sd_ok, ch_ok;

  assign lbl_ok = (entry_i.label == '0) || (entry_i.label == label_i);
  assign sd_ok  = entry_i.sd_any || (entry_i.sd == sd_i) || (allcall_i && sd_i == '0);
  assign ch_ok  = (8'(entry_i.chan) == 8'(ch_i));
  assign hit_o  = lbl_ok && sd_ok && ch_ok;
endmodule

// File: rtl/a429_label_filter.sv
module a429_label_filter
  import a429_filt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DEPTH  = 128,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tbl_we_i,
  input  logic [IDX_W-1:0]       tbl_addr_i,
  input  logic [ENT_W-1:0]       tbl_wdata_i,
  input  logic                   allcall_we_i,
  input  logic [N_CH-1:0]        allcall_wdata_i,
  input  logic [N_CH-1:0]        word_valid_i,
  input  logic [N_CH*WORD_W-1:0] word_data_i,
  output logic [N_CH-1:0]        word_ack_o,
  output logic                   busy_o,
  output logic                   store_o,
  output logic [IDX_W-1:0]       ram_addr_o,
  output logic                   fifo_push_o,
  output logic [1:0]             irq_sel_o,
  output logic [CH_W-1:0]        out_ch_o,
  output logic [WORD_W-1:0]      out_word_o,
  output logic                   nomatch_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  state_t            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic [CH_W-1:0]   ch_q;
  logic [N_CH-1:0]   allcall_q;
  logic [N_CH-1:0]   gnt;
  logic [CH_W-1:0]   gnt_idx;
  entry_t            cur_ent;
  logic              hit;

  logic              store_q, nomatch_q, fifo_q;
  logic [1:0]        irq_q;
  logic [IDX_W-1:0]  addr_q;
  logic [CH_W-1:0]   och_q;
  logic [WORD_W-1:0] oword_q;

  a429_prio_arb #(.N_CH(N_CH)) u_arb (
    .req_i     (word_valid_i),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  a429_match_tbl #(.DEPTH(DEPTH)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (idx_q),
    .rdata_o (cur_ent)
  );

  a429_entry_cmp #(.CH_W(CH_W)) u_cmp (
    .entry_i   (cur_ent),
    .label_i   (word_q[LBL_W-1:0]),
    .sd_i      (word_q[LBL_W+SD_W-1:LBL_W]),
    .ch_i      (ch_q),
    .allcall_i (allcall_q[ch_q]),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) allcall_q <= '0;
    else if (allcall_we_i) allcall_q <= allcall_wdata_i;
  end

  assign word_ack_o = (state_q == ST_IDLE) ? gnt : '0;
  assign busy_o     = (state_q == ST_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      word_q    <= '0;
      ch_q      <= '0;
      store_q   <= 1'b0;
      nomatch_q <= 1'b0;
      fifo_q    <= 1'b0;
      irq_q     <= '0;
      addr_q    <= '0;
      och_q     <= '0;
      oword_q   <= '0;
    end else begin
      store_q   <= 1'b0;
      nomatch_q <= 1'b0;
      fifo_q    <= 1'b0;
      irq_q     <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (|word_valid_i) begin
            word_q  <= word_data_i[gnt_idx*WORD_W +: WORD_W];
            ch_q    <= gnt_idx;
            idx_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            store_q <= 1'b1;
            fifo_q  <= cur_ent.fifo;
            irq_q   <= cur_ent.irq;
            addr_q  <= idx_q;
            och_q   <= ch_q;
            oword_q <= word_q;
            state_q <= ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            nomatch_q <= 1'b1;
            och_q     <= ch_q;
            oword_q   <= word_q;
            state_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign store_o     = store_q;
  assign nomatch_o   = nomatch_q;
  assign fifo_push_o = fifo_q;
  assign irq_sel_o   = irq_q;
  assign ram_addr_o  = addr_q;
  assign out_ch_o    = och_q;
  assign out_word_o  = oword_q;

  // R7: a result is either kept or missed, never both
  a_r7_hit_or_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && nomatch_o));
  // R8: strobes last one cycle
  a_r8_store_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);
  a_r8_miss_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nomatch_o |=> !nomatch_o);
  // R6: qualifiers only with the store strobe
  a_r6_fifo_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> store_o);
  a_r6_irq_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sel_o != 2'b00) |-> store_o);
  // R9: one winner, only from a requester, none while busy
  a_r9_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(word_ack_o));
  a_r9_ack_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ack_o & ~word_valid_i) == '0);
  a_r9_busy_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (word_ack_o == '0));
  // R8: a result ends the scan
  a_r8_result_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || nomatch_o) |-> !busy_o);
endmodule

// File: tb/a429_label_filter_bench.sv
`timescale 1ns/1ps
module a429_label_filter_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tbl_we_i = 1'b0;
  logic [6:0]   tbl_addr_i = '0;
  logic [15:0]  tbl_wdata_i = '0;
  logic         allcall_we_i = 1'b0;
  logic [3:0]   allcall_wdata_i = '0;
  logic [3:0]   word_valid_i = '0;
  logic [127:0] word_data_i = '0;
  logic [3:0]   word_ack_o;
  logic         busy_o, store_o, fifo_push_o, nomatch_o;
  logic [6:0]   ram_addr_o;
  logic [1:0]   irq_sel_o, out_ch_o;
  logic [31:0]  out_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  a429_label_filter u_a429_label_filter (.*);

  // entry = {irq, chan, fifo, sd_any, sd, label}
  function automatic logic [15:0] mk(logic [1:0] irq, logic [1:0] ch, logic ff,
                                     logic any, logic [1:0] sd, logic [7:0] lbl);
    return {irq, ch, ff, any, sd, lbl};
  endfunction

  function automatic logic [15:0] tbl_init(int i);
    case (i)
      0:       return mk(2'd3, 2'd0, 1'b1, 1'b0, 2'b01, 8'h55);
      5:       return mk(2'd2, 2'd1, 1'b1, 1'b0, 2'b10, 8'h31);
      6:       return mk(2'd0, 2'd1, 1'b0, 1'b1, 2'b00, 8'h31);
      10:      return mk(2'd3, 2'd2, 1'b0, 1'b0, 2'b11, 8'h00);
      20:      return mk(2'd1, 2'd3, 1'b1, 1'b0, 2'b10, 8'h44);
      127:     return mk(2'd1, 2'd0, 1'b0, 1'b1, 2'b00, 8'h77);
      default: return mk(2'd0, 2'd3, 1'b0, 1'b0, 2'b11, 8'hFF);
    endcase
  endfunction

  // {ch, word, hit, idx, fifo, irq}
  localparam int NV = 10;
  localparam logic [44:0] VEC [NV] = '{
    {2'd1, {22'h12345, 2'b10, 8'h31}, 1'b1, 7'd5,   1'b1, 2'd2}, // R5 first of 5/6
    {2'd1, {22'h00001, 2'b01, 8'h31}, 1'b1, 7'd6,   1'b0, 2'd0}, // R2 sd wildcard
    {2'd2, {22'h3FFFF, 2'b01, 8'h31}, 1'b0, 7'd0,   1'b0, 2'd0}, // R2 sd mismatch
    {2'd2, {22'h2AAAA, 2'b11, 8'hAB}, 1'b1, 7'd10,  1'b0, 2'd3}, // R1 label wildcard
    {2'd3, {22'h15555, 2'b10, 8'h44}, 1'b1, 7'd20,  1'b1, 2'd1}, // R6
    {2'd3, {22'h00F0F, 2'b00, 8'h44}, 1'b0, 7'd0,   1'b0, 2'd0}, // R3 all-call off
    {2'd0, {22'h0BEEF, 2'b10, 8'h77}, 1'b1, 7'd127, 1'b0, 2'd1}, // R8 last entry
    {2'd0, {22'h1CAFE, 2'b01, 8'h55}, 1'b1, 7'd0,   1'b1, 2'd3}, // R5 entry 0
    {2'd0, {22'h00000, 2'b10, 8'h31}, 1'b0, 7'd0,   1'b0, 2'd0}, // R4 channel mismatch
    {2'd1, {22'h0ABCD, 2'b10, 8'h32}, 1'b0, 7'd0,   1'b0, 2'd0}  // R1 label mismatch
  };

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tbl_write(int a, logic [15:0] d);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_addr_i = 7'(a); tbl_wdata_i = d;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic set_allcall(logic [3:0] v);
    @(negedge clk_i);
    allcall_we_i = 1'b1; allcall_wdata_i = v;
    @(negedge clk_i);
    allcall_we_i = 1'b0;
  endtask

  // wait for a result, return edges since acceptance (called at the negedge after acceptance)
  task automatic wait_result(output int lat);
    lat = 0;
    while (!(store_o || nomatch_o) && lat < 300) begin
      @(posedge clk_i); @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic send(int ch, logic [31:0] w, bit hit, int idx, bit ff, int irq, string req);
    int lat;
    @(negedge clk_i);
    word_data_i[ch*32 +: 32] = w;
    word_valid_i[ch] = 1'b1;
    #1;
    chk(word_ack_o == 4'(1 << ch), "R9", "ack", word_ack_o, 4'(1 << ch));
    @(posedge clk_i); @(negedge clk_i);
    word_valid_i[ch] = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy in scan", busy_o, 1);
    wait_result(lat);
    chk(store_o == hit, req, "store", store_o, hit);
    chk(nomatch_o == !hit, "R7", "nomatch", nomatch_o, !hit);
    chk(lat == (hit ? idx + 1 : 128), "R8", "latency", lat, hit ? idx + 1 : 128);
    chk(out_ch_o == 2'(ch) && out_word_o == w, "R8", "out ch/word", {out_ch_o, out_word_o}, {2'(ch), w});
    if (hit) begin
      chk(ram_addr_o == 7'(idx), req, "ram addr", ram_addr_o, idx);
      chk(fifo_push_o == ff && irq_sel_o == 2'(irq), "R6", "fifo/irq",
          {fifo_push_o, irq_sel_o}, {ff, 2'(irq)});
    end else begin
      chk(fifo_push_o == 1'b0 && irq_sel_o == 2'd0, "R6", "qual on miss",
          {fifo_push_o, irq_sel_o}, 0);
    end
    @(posedge clk_i); @(negedge clk_i);
    chk(!store_o && !nomatch_o, "R8", "strobe width", {store_o, nomatch_o}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!busy_o && !store_o && !nomatch_o && !fifo_push_o && irq_sel_o == 0 && word_ack_o == 0,
        "R11", "reset outputs", {busy_o, store_o, nomatch_o, fifo_push_o, irq_sel_o, word_ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !store_o && !nomatch_o, "R11", "after release", {busy_o, store_o, nomatch_o}, 0);

    for (int i = 0; i < 128; i++) tbl_write(i, tbl_init(i));

    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      e = VEC[v];
      send(int'(e[44:43]), e[42:11], e[10], int'(e[9:3]), e[2], int'(e[1:0]), "R5");
    end

    // R3: all-call only for the receiving channel
    set_allcall(4'b0100);
    send(3, {22'h00F0F, 2'b00, 8'h44}, 1'b0, 0, 1'b0, 0, "R3");
    set_allcall(4'b1000);
    send(3, {22'h00F0F, 2'b00, 8'h44}, 1'b1, 20, 1'b1, 1, "R3");
    send(3, {22'h00F0F, 2'b01, 8'h44}, 1'b0, 0, 1'b0, 0, "R3");
    set_allcall(4'b0000);

    // R9: ch1 and ch2 together, ch1 first, ch2 held off until idle
    @(negedge clk_i);
    word_data_i[32 +: 32] = {22'h00001, 2'b01, 8'h31};
    word_data_i[64 +: 32] = {22'h2AAAA, 2'b11, 8'hAB};
    word_valid_i = 4'b0110;
    #1;
    chk(word_ack_o == 4'b0010, "R9", "priority ack", word_ack_o, 4'b0010);
    @(posedge clk_i); @(negedge clk_i);
    word_valid_i[1] = 1'b0;
    chk(word_ack_o == 4'b0000 && busy_o, "R9", "hold off while busy", word_ack_o, 0);
    wait_result(lat);
    chk(store_o && out_ch_o == 2'd1 && ram_addr_o == 7'd6, "R9", "first winner result",
        {store_o, out_ch_o, ram_addr_o}, {1'b1, 2'd1, 7'd6});
    chk(word_ack_o == 4'b0100, "R9", "second taken when idle", word_ack_o, 4'b0100);
    @(posedge clk_i); @(negedge clk_i);
    word_valid_i[2] = 1'b0;
    wait_result(lat);
    chk(store_o && out_ch_o == 2'd2 && ram_addr_o == 7'd10 && lat == 11, "R9",
        "second winner result", {store_o, out_ch_o, ram_addr_o, 8'(lat)},
        {1'b1, 2'd2, 7'd10, 8'd11});

    // R10: rewrite entry 6 so it no longer matches; then move label 0x31 sd01 to entry 3
    tbl_write(6, mk(2'd0, 2'd3, 1'b0, 1'b0, 2'b11, 8'hFF));
    send(1, {22'h00001, 2'b01, 8'h31}, 1'b0, 0, 1'b0, 0, "R10");
    tbl_write(3, mk(2'd2, 2'd1, 1'b1, 1'b0, 2'b01, 8'h31));
    send(1, {22'h00001, 2'b01, 8'h31}, 1'b1, 3, 1'b1, 2, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule